// File: doc/BRIEF.md
# MOESIF Snooping Line Coherence Controller

This block keeps the coherence state of every line of a small snooping private cache and decides, for each event presented to it, what the line becomes and what the cache must do on the shared bus. It tracks six states. Two of them split responsibilities that a four-state scheme folds together. Owned marks a dirty line that other caches may also hold as Shared, and its holder must write the line back when it leaves. Forward marks a clean shared line whose holder answers other caches' fills directly.

One event arrives per cycle. An event carries a kind, a line index and, for fills, a shared indication sampled from the bus. On the next cycle the block reports the registered result: the state before the event, the state after it, the bus request to issue, and whether this cache must drive data cache-to-cache or write the line back. It also reports an error when the event cannot legally occur in the line's current state. The data arrays, the bus arbiter and memory sit outside the block.

Top module: `moesif_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code 0) and `out_valid` is 0. State codes: Invalid 0, Shared 1, Forward 2, Exclusive 3, Owned 4, Modified 5.
- R2: The result of an event is registered. It appears with `out_valid`=1 one cycle after `ev_valid`=1 and carries in `out_prev` the line's state before the event. A cycle with `ev_valid`=0 yields `out_valid`=0 and changes no line.
- R3: A local read (event code 0) of an Invalid line issues a bus read (request code 1). The line goes to Exclusive when `fill_shared`=0 and to Forward when `fill_shared`=1. A local read of any valid line is a hit: request code 0 and state unchanged.
- R4: A local write (event code 1) in Shared, Forward or Owned issues an upgrade (request code 3) and moves to Modified. In Exclusive it moves to Modified with no request. In Invalid it issues a read-for-ownership (request code 2) and moves to Modified. In Modified it changes nothing.
- R5: A snooped bus read (event code 3) moves Modified to Owned with data supplied. Owned stays Owned and supplies data. Forward moves to Shared and supplies data. Exclusive moves to Shared without supplying. Shared and Invalid are unchanged.
- R6: A snooped bus write (event code 4) invalidates any valid line. A snooped upgrade (event code 5) invalidates Shared, Forward and Owned lines. A Modified or Owned line asserts `out_supply` while invalidating.
- R7: A local eviction (event code 2) of a Modified or Owned line asserts `out_wb`, issues a write-back (request code 4) and leaves the line Invalid. An eviction of a Shared, Forward or Exclusive line drops it to Invalid with no request.
- R8: The following events raise `out_err` and leave the state unchanged, with request code 0 and no supply or write-back: eviction of an Invalid line, a snooped upgrade on an Exclusive or Modified line, and event codes 6 and 7.
- R9: Lines are independent: an event changes only the indexed line. An event to the same line in the very next cycle sees the state written by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_kind | input | 3 | Event code (see R3 to R8) |
| ev_line | input | IDX_W | Index of the line the event concerns |
| fill_shared | input | 1 | Another cache holds the line; used by a local read miss |
| out_valid | output | 1 | Result of last cycle's event is present |
| out_prev | output | 3 | Line state before the event |
| out_state | output | 3 | Line state after the event |
| out_bus | output | 3 | Bus request: 0 none, 1 read, 2 read-for-ownership, 3 upgrade, 4 write-back |
| out_supply | output | 1 | This cache drives the line's data cache-to-cache |
| out_wb | output | 1 | This cache writes the line back to memory |
| out_err | output | 1 | Event illegal in the line's current state |

## Verification
The state write of one event and the state lookup of the next both take place in the same cycle when consecutive events name the same line. The next event must see the freshly written state, not the old entry. The bench provokes this with back-to-back events to one line, such as a write followed at once by a snooped read. It judges the outcome by the second result's `out_prev` and `out_state`, which must follow from the first result's new state. Interleaving events to another line between them checks that the update reached only the indexed line.

// File: rtl/moesif_pkg.sv
package moesif_pkg;
  localparam int ST_W  = 3;
  localparam int EV_W  = 3;
  localparam int BUS_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_I = 3'd0, ST_S = 3'd1, ST_F = 3'd2,
    ST_E = 3'd3, ST_O = 3'd4, ST_M = 3'd5
  } line_st_e;

  typedef enum logic [EV_W-1:0] {
    EV_LRD = 3'd0, EV_LWR = 3'd1, EV_LEV = 3'd2,
    EV_BRD = 3'd3, EV_BWR = 3'd4, EV_BUP = 3'd5
  } ev_kind_e;

  typedef enum logic [BUS_W-1:0] {
    BUS_NONE = 3'd0, BUS_RD = 3'd1, BUS_RFO = 3'd2,
    BUS_UPG = 3'd3, BUS_WB = 3'd4
  } bus_req_e;

  typedef struct packed {
    line_st_e nxt;
    bus_req_e bus;
    logic     supply;
    logic     wb;
    logic     err;
  } decision_t;
endpackage

// File: rtl/moesif_decide.sv
module moesif_decide
  import moesif_pkg::*;
(
  input  logic [ST_W-1:0] cur,
  input  logic [EV_W-1:0] ev,
  input  logic            shared,
  output decision_t       dec
);
  line_st_e cs;
  assign cs = line_st_e'(cur);

  always_comb begin
    dec.nxt    = cs;
    dec.bus    = BUS_NONE;
    dec.supply = 1'b0;
    dec.wb     = 1'b0;
    dec.err    = 1'b0;
    case (ev)
      EV_LRD: begin
        if (cs == ST_I) begin
          dec.bus = BUS_RD;
          dec.nxt = shared ? ST_F : ST_E;
        end
      end
      EV_LWR: begin
        case (cs)
          ST_I:                 begin dec.bus = BUS_RFO; dec.nxt = ST_M; end
          ST_S, ST_F, ST_O:     begin dec.bus = BUS_UPG; dec.nxt = ST_M; end
          ST_E:                 dec.nxt = ST_M;
          default:              dec.nxt = cs;
        endcase
      end
      EV_LEV: begin
        case (cs)
          ST_I:             dec.err = 1'b1;
          ST_M, ST_O:       begin dec.bus = BUS_WB; dec.wb = 1'b1; dec.nxt = ST_I; end
          default:          dec.nxt = ST_I;
        endcase
      end
      EV_BRD: begin
        case (cs)
          ST_M:    begin dec.nxt = ST_O; dec.supply = 1'b1; end
          ST_O:    dec.supply = 1'b1;
          ST_F:    begin dec.nxt = ST_S; dec.supply = 1'b1; end
          ST_E:    dec.nxt = ST_S;
          default: dec.nxt = cs;
        endcase
      end
      EV_BWR: begin
        if (cs != ST_I) dec.nxt = ST_I;
        if (cs == ST_M || cs == ST_O) dec.supply = 1'b1;
      end
      EV_BUP: begin
        case (cs)
          ST_E, ST_M: dec.err = 1'b1;
          ST_O:       begin dec.nxt = ST_I; dec.supply = 1'b1; end
          ST_S, ST_F: dec.nxt = ST_I;
          default:    dec.nxt = cs;
        endcase
      end
      default: dec.err = 1'b1;
    endcase
  end
endmodule

// File: rtl/moesif_line_store.sv
module moesif_line_store #(
  parameter int LINES = 16,
  parameter int W     = 3,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data
);
  logic [W-1:0] cells [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)
        cells[g] <= '0;
      else if (we && wr_idx == IDX_W'(g))
        cells[g] <= wr_data;
    end
  end

  assign rd_data = cells[rd_idx];
endmodule

// File: rtl/moesif_line_ctrl.sv
module moesif_line_ctrl
  import moesif_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_valid,
  input  logic [2:0]       ev_kind,
  input  logic [IDX_W-1:0] ev_line,
  input  logic             fill_shared,
  output logic             out_valid,
  output logic [2:0]       out_prev,
  output logic [2:0]       out_state,
  output logic [2:0]       out_bus,
  output logic             out_supply,
  output logic             out_wb,
  output logic             out_err
);
  logic [ST_W-1:0] cur_st;
  decision_t       dec;

  moesif_line_store #(.LINES(LINES), .W(ST_W)) store_i (
    .clk    (clk),
    .rst    (rst),
    .rd_idx (ev_line),
    .rd_data(cur_st),
    .we     (ev_valid),
    .wr_idx (ev_line),
    .wr_data(dec.nxt)
  );

  moesif_decide decide_i (
    .cur   (cur_st),
    .ev    (ev_kind),
    .shared(fill_shared),
    .dec   (dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_prev   <= '0;
      out_state  <= '0;
      out_bus    <= '0;
      out_supply <= 1'b0;
      out_wb     <= 1'b0;
      out_err    <= 1'b0;
    end else begin
      out_valid  <= ev_valid;
      out_prev   <= cur_st;
      out_state  <= dec.nxt;
      out_bus    <= dec.bus;
      out_supply <= ev_valid & dec.supply;
      out_wb     <= ev_valid & dec.wb;
      out_err    <= ev_valid & dec.err;
    end
  end
endmodule

// File: rtl/moesif_line_ctrl_chk.sv
module moesif_line_ctrl_chk #(
  parameter int LINES = 16,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             ev_valid,
  input logic [2:0]       ev_kind,
  input logic [IDX_W-1:0] ev_line,
  input logic             out_valid,
  input logic [2:0]       out_prev,
  input logic [2:0]       out_state,
  input logic [2:0]       out_bus,
  input logic             out_supply,
  input logic             out_wb,
  input logic             out_err
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(ev_valid));

  assert_err_inert_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_state == out_prev && out_bus == 3'd0 && !out_supply && !out_wb));

  assert_fill_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_bus == 3'd1) |-> (out_prev == 3'd0 && (out_state == 3'd3 || out_state == 3'd2)));

  assert_upgrade_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_bus == 3'd3) |-> (out_state == 3'd5 && (out_prev == 3'd1 || out_prev == 3'd2 || out_prev == 3'd4)));

  assert_snoop_read_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(ev_kind) == 3'd3 && out_prev == 3'd5) |-> (out_state == 3'd4 && out_supply));

  assert_supply_src_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_supply) |-> (out_prev == 3'd2 || out_prev == 3'd4 || out_prev == 3'd5));

  assert_writeback_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_wb) |-> (out_state == 3'd0 && out_bus == 3'd4 && (out_prev == 3'd4 || out_prev == 3'd5)));

  assert_chain_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid) && $past(ev_line) == $past(ev_line, 2)) |-> (out_prev == $past(out_state)));
endmodule

bind moesif_line_ctrl moesif_line_ctrl_chk #(.LINES(LINES)) chk_i (
  .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_line(ev_line),
  .out_valid(out_valid), .out_prev(out_prev), .out_state(out_state), .out_bus(out_bus),
  .out_supply(out_supply), .out_wb(out_wb), .out_err(out_err)
);

// File: tb/moesif_line_ctrl_tb_top.sv
module moesif_line_ctrl_tb_top;
  localparam int LINES = 16;
  localparam int IDX_W = $clog2(LINES);

  localparam logic [2:0] I = 3'd0, S = 3'd1, F = 3'd2, E = 3'd3, O = 3'd4, M = 3'd5;
  localparam logic [2:0] LRD = 3'd0, LWR = 3'd1, LEV = 3'd2, BRD = 3'd3, BWR = 3'd4, BUP = 3'd5;
  localparam logic [2:0] NB = 3'd0, RD = 3'd1, RFO = 3'd2, UPG = 3'd3, WB = 3'd4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_valid = 1'b0;
  logic [2:0] ev_kind = 3'd0;
  logic [IDX_W-1:0] ev_line = '0;
  logic fill_shared = 1'b0;
  logic out_valid, out_supply, out_wb, out_err;
  logic [2:0] out_prev, out_state, out_bus;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  moesif_line_ctrl #(.LINES(LINES)) dut_i (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_line(ev_line),
    .fill_shared(fill_shared), .out_valid(out_valid), .out_prev(out_prev),
    .out_state(out_state), .out_bus(out_bus), .out_supply(out_supply),
    .out_wb(out_wb), .out_err(out_err)
  );

  task automatic send(input logic [2:0] k, input int ln, input logic sh);
    ev_valid    = 1'b1;
    ev_kind     = k;
    ev_line     = IDX_W'(ln);
    fill_shared = sh;
    @(negedge clk);
  endtask

  task automatic idle();
    ev_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic [2:0] p, input logic [2:0] n,
                     input logic [2:0] b, input logic sp, input logic w, input logic e);
    checks++;
    if (out_valid !== 1'b1 || out_prev !== p || out_state !== n || out_bus !== b ||
        out_supply !== sp || out_wb !== w || out_err !== e) begin
      fails++;
      $display("FAIL %s: got v=%0d prev=%0d st=%0d bus=%0d sup=%0d wb=%0d err=%0d exp prev=%0d st=%0d bus=%0d sup=%0d wb=%0d err=%0d",
               rq, out_valid, out_prev, out_state, out_bus, out_supply, out_wb, out_err,
               p, n, b, sp, w, e);
    end
  endtask

  // bring a line to a known state starting from a snooped write
  task automatic goto(input int ln, input logic [2:0] st);
    send(BWR, ln, 1'b0);
    case (st)
      S: begin send(LRD, ln, 1'b1); send(BRD, ln, 1'b0); end
      F: send(LRD, ln, 1'b1);
      E: send(LRD, ln, 1'b0);
      O: begin send(LRD, ln, 1'b0); send(LWR, ln, 1'b0); send(BRD, ln, 1'b0); end
      M: begin send(LRD, ln, 1'b0); send(LWR, ln, 1'b0); end
      default: ;
    endcase
  endtask

  task automatic t_reset();
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: out_valid=%0d exp 0 after reset", out_valid);
    end
    send(BRD, 5, 1'b0); chk("R1 line5 invalid", I, I, NB, 0, 0, 0);
    send(BRD, 15, 1'b0); chk("R1 line15 invalid", I, I, NB, 0, 0, 0);
    idle();
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R2: out_valid=%0d exp 0 on idle", out_valid);
    end
  endtask

  task automatic t_read();
    goto(1, I); send(LRD, 1, 1'b0); chk("R3 miss no sharer", I, E, RD, 0, 0, 0);
    goto(1, I); send(LRD, 1, 1'b1); chk("R3 miss sharer", I, F, RD, 0, 0, 0);
    goto(1, O); send(LRD, 1, 1'b1); chk("R3 hit O", O, O, NB, 0, 0, 0);
    goto(1, S); send(LRD, 1, 1'b0); chk("R3 hit S", S, S, NB, 0, 0, 0);
  endtask

  task automatic t_write();
    goto(2, S); send(LWR, 2, 1'b0); chk("R4 S upgrade", S, M, UPG, 0, 0, 0);
    goto(2, F); send(LWR, 2, 1'b0); chk("R4 F upgrade", F, M, UPG, 0, 0, 0);
    goto(2, O); send(LWR, 2, 1'b0); chk("R4 O upgrade", O, M, UPG, 0, 0, 0);
    goto(2, E); send(LWR, 2, 1'b0); chk("R4 E silent", E, M, NB, 0, 0, 0);
    goto(2, I); send(LWR, 2, 1'b0); chk("R4 I rfo", I, M, RFO, 0, 0, 0);
    send(LWR, 2, 1'b0); chk("R4 M hit", M, M, NB, 0, 0, 0);
  endtask

  task automatic t_busrd();
    goto(3, M); send(BRD, 3, 1'b0); chk("R5 M->O", M, O, NB, 1, 0, 0);
    send(BRD, 3, 1'b0); chk("R5 O stays", O, O, NB, 1, 0, 0);
    goto(3, F); send(BRD, 3, 1'b0); chk("R5 F->S", F, S, NB, 1, 0, 0);
    goto(3, E); send(BRD, 3, 1'b0); chk("R5 E->S", E, S, NB, 0, 0, 0);
    send(BRD, 3, 1'b0); chk("R5 S stays", S, S, NB, 0, 0, 0);
  endtask

  task automatic t_inval();
    goto(4, M); send(BWR, 4, 1'b0); chk("R6 bwr M", M, I, NB, 1, 0, 0);
    goto(4, O); send(BWR, 4, 1'b0); chk("R6 bwr O", O, I, NB, 1, 0, 0);
    goto(4, E); send(BWR, 4, 1'b0); chk("R6 bwr E", E, I, NB, 0, 0, 0);
    goto(4, F); send(BUP, 4, 1'b0); chk("R6 bup F", F, I, NB, 0, 0, 0);
    goto(4, S); send(BUP, 4, 1'b0); chk("R6 bup S", S, I, NB, 0, 0, 0);
    goto(4, O); send(BUP, 4, 1'b0); chk("R6 bup O", O, I, NB, 1, 0, 0);
  endtask

  task automatic t_evict();
    goto(6, M); send(LEV, 6, 1'b0); chk("R7 evict M", M, I, WB, 0, 1, 0);
    goto(6, O); send(LEV, 6, 1'b0); chk("R7 evict O", O, I, WB, 0, 1, 0);
    goto(6, F); send(LEV, 6, 1'b0); chk("R7 evict F", F, I, NB, 0, 0, 0);
    goto(6, E); send(LEV, 6, 1'b0); chk("R7 evict E", E, I, NB, 0, 0, 0);
    goto(6, S); send(LEV, 6, 1'b0); chk("R7 evict S", S, I, NB, 0, 0, 0);
  endtask

  task automatic t_err();
    goto(7, I); send(LEV, 7, 1'b0); chk("R8 evict I", I, I, NB, 0, 0, 1);
    goto(7, E); send(BUP, 7, 1'b0); chk("R8 bup E", E, E, NB, 0, 0, 1);
    send(LRD, 7, 1'b0); chk("R8 E kept", E, E, NB, 0, 0, 0);
    goto(7, M); send(BUP, 7, 1'b0); chk("R8 bup M", M, M, NB, 0, 0, 1);
    send(3'd6, 7, 1'b0); chk("R8 code6", M, M, NB, 0, 0, 1);
    send(3'd7, 7, 1'b1); chk("R8 code7", M, M, NB, 0, 0, 1);
    idle();
    send(LRD, 7, 1'b0); chk("R8 M kept", M, M, NB, 0, 0, 0);
  endtask

  task automatic t_indep();
    goto(8, M); goto(9, F);
    send(LRD, 8, 1'b0); chk("R9 line8 kept", M, M, NB, 0, 0, 0);
    send(LRD, 9, 1'b0); chk("R9 line9 kept", F, F, NB, 0, 0, 0);
    goto(10, I);
    send(LRD, 10, 1'b0); chk("R9 b2b fill", I, E, RD, 0, 0, 0);
    send(LWR, 10, 1'b0); chk("R9 b2b write", E, M, NB, 0, 0, 0);
    send(BRD, 10, 1'b0); chk("R9 b2b snoop", M, O, NB, 1, 0, 0);
    send(LEV, 10, 1'b0); chk("R9 b2b evict", O, I, WB, 0, 1, 0);
    send(LRD, 9, 1'b0); chk("R9 line9 untouched", F, F, NB, 0, 0, 0);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read();
    t_write();
    t_busrd();
    t_inval();
    t_evict();
    t_err();
    t_indep();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule